// File: doc/BRIEF.md
# Serial Register Access Port

This block is a synchronous serial slave that reads and writes a small bank of configuration registers. A host drives a serial clock and shifts in an instruction byte that gives the direction and the register address. The data bytes follow; their number depends on the register addressed. Once the last data bit is counted, the next bit begins a new instruction. No chip select is needed. An asynchronous abort input ends a transaction at any point, so host and slave can realign.

Writes land in a buffer bank in the serial clock domain. A separate update strobe, sampled on a system clock, copies the whole buffer to the active outputs. Two bits of the active register 0 set the serial format. Bit 0 selects least-significant-first order, which also reverses the byte sequence. Bit 1 moves read data from the shared bidirectional pin to a dedicated output pin. The shared pin is modelled as an input, an output and an output enable. The serial pins are plain control signals; the block has no stream interface, so no back-pressure rules apply.

Top module: `srap_port`

## Requirements
- R1: The instruction byte takes bit 7 as read (1) or write (0) and bits 4:0 as the register address; bits 6:5 are ignored.
- R2: Input bits are captured on the rising serial clock edge; read data bits change only after a falling edge and are stable at the following rising edge.
- R3: An even address carries 4 data bytes (32-bit register) and an odd address 3 data bytes (24-bit register); the bit after the last data bit is the first bit of a new instruction.
- R4: With active register 0 bit 0 clear, each field is sent most significant bit first: instruction bit 7 first, then data from the top bit of the register down to bit 0.
- R5: With active register 0 bit 0 set, each field is sent least significant bit first: instruction bit 0 first, data starting at the lowest byte and moving to higher bytes, bit 0 first.
- R6: With active register 0 bit 1 clear (2-wire), input comes from `sdio_i`, read data goes on `sdio_o`, and `sdio_oe` is high only during the data phase of a read. With the bit set (3-wire), input comes from `sdi`, read data goes on `sdo`, and `sdio_oe` stays low.
- R7: Raising `sync_abort` ends the transaction at once. `sdio_oe` and `sdo` go low, and a partly shifted write leaves the register unchanged. After it falls, the next bit starts an instruction.
- R8: A write changes only the buffer, which reads return. `cfg_o` changes only in the cycle after `io_update` is sampled high on a rising `sync_clk`, and then equals the buffer.
- R9: The upper byte of each odd (24-bit) register reads and outputs as zero. Addresses at or above NUM_REGS count 4 bytes, ignore writes and read as zero.
- R10: While `rst` is high, all registers, `cfg_o`, `sdo` and `sdio_oe` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous active-high reset of the whole block |
| sclk | input | 1 | Serial clock from the host |
| sync_abort | input | 1 | Asynchronous active-high transaction abort |
| sdi | input | 1 | Serial data input in 3-wire mode |
| sdio_i | input | 1 | Shared pin, input side (2-wire mode) |
| sdio_o | output | 1 | Shared pin, output side |
| sdio_oe | output | 1 | Output enable for the shared pin |
| sdo | output | 1 | Serial data output in 3-wire mode |
| sync_clk | input | 1 | System clock that samples the update strobe |
| io_update | input | 1 | Copies the buffer bank to the active outputs |
| cfg_o | output | NUM_REGS*32 | Active registers, register i at bits 32*i+31:32*i |

## Verification
A wrong bit counter or a wrong byte length from the address decode misaligns framing. The symptom shows on the very next transaction, as a write to the wrong register or garbled read data, so every test runs back-to-back transactions. A wrong order flag shows as a bit-reversed or byte-swapped value at the first readback or update. A missed abort or a stuck enable shows as `sdio_oe` high or a changed register on the first update after the abort.

// File: rtl/srap_pkg.sv
package srap_pkg;
  localparam int REG_W = 32;
  localparam int CNT_W = 6;

  typedef enum logic {PH_INSTR = 1'b0, PH_DATA = 1'b1} phase_t;

  // data-phase length in bits for a register address
  function automatic logic [CNT_W-1:0] reg_bits(input logic [4:0] addr, input int num_regs);
    if (int'(addr) < num_regs && addr[0]) return CNT_W'(24);
    return CNT_W'(32);
  endfunction

  function automatic logic [REG_W-1:0] reg_mask(input int idx);
    return (idx % 2 == 1) ? 32'h00FF_FFFF : 32'hFFFF_FFFF;
  endfunction
endpackage

// File: rtl/srap_shift.sv
module srap_shift
  import srap_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 5
) (
  input  logic              rst,
  input  logic              sclk,
  input  logic              sync_abort,
  input  logic              din,
  input  logic              lsb_first,
  output logic              wr_en,
  output logic [ADDR_W-1:0] addr,
  output logic [REG_W-1:0]  wr_data,
  output logic              rd,
  output logic              data_ph,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  nbits
);
  phase_t           phase;
  logic [7:0]       ins, ins_nx;
  logic [REG_W-1:0] sh, sh_nx;
  logic             last;

  assign ins_nx  = lsb_first ? {din, ins[7:1]} : {ins[6:0], din};
  assign sh_nx   = lsb_first ? {din, sh[REG_W-1:1]} : {sh[REG_W-2:0], din};
  assign last    = (cnt == nbits - CNT_W'(1));
  assign data_ph = (phase == PH_DATA);
  assign wr_en   = data_ph && !rd && last;
  assign wr_data = lsb_first ? (sh_nx >> (CNT_W'(REG_W) - nbits)) : sh_nx;

  always_ff @(posedge sclk or posedge rst or posedge sync_abort) begin
    if (rst || sync_abort) begin
      phase <= PH_INSTR;
      cnt   <= '0;
      ins   <= '0;
      sh    <= '0;
      rd    <= 1'b0;
      addr  <= '0;
      nbits <= CNT_W'(REG_W);
    end else if (phase == PH_INSTR) begin
      ins <= ins_nx;
      if (cnt == CNT_W'(7)) begin
        rd    <= ins_nx[7];
        addr  <= ins_nx[ADDR_W-1:0];
        nbits <= reg_bits(ins_nx[4:0], NUM_REGS);
        phase <= PH_DATA;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else begin
      sh <= sh_nx;
      if (last) begin
        phase <= PH_INSTR;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/srap_regbank.sv
module srap_regbank
  import srap_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 5
) (
  input  logic                      rst,
  input  logic                      sclk,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [REG_W-1:0]          wr_data,
  output logic [REG_W-1:0]          rd_data,
  input  logic                      sync_clk,
  input  logic                      io_update,
  output logic [NUM_REGS*REG_W-1:0] buf_flat,
  output logic [NUM_REGS*REG_W-1:0] act_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [REG_W-1:0] bufr, actr;
    always_ff @(posedge sclk or posedge rst) begin
      if (rst) bufr <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i)) bufr <= wr_data & reg_mask(i);
    end
    always_ff @(posedge sync_clk or posedge rst) begin
      if (rst) actr <= '0;
      else if (io_update) actr <= bufr;
    end
    assign buf_flat[i*REG_W +: REG_W] = bufr;
    assign act_flat[i*REG_W +: REG_W] = actr;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (wr_addr == ADDR_W'(i)) rd_data = buf_flat[i*REG_W +: REG_W];
  end
endmodule

// File: rtl/srap_txout.sv
module srap_txout
  import srap_pkg::*;
(
  input  logic             rst,
  input  logic             sclk,
  input  logic             sync_abort,
  input  logic             lsb_first,
  input  logic             three_wire,
  input  logic             data_ph,
  input  logic             rd,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] nbits,
  input  logic [REG_W-1:0] rd_data,
  output logic             sdio_o,
  output logic             sdio_oe,
  output logic             sdo
);
  logic [CNT_W-1:0] idx;
  logic             out_bit, rd_act;

  assign idx = lsb_first ? cnt : (nbits - CNT_W'(1) - cnt);

  always_ff @(negedge sclk or posedge rst or posedge sync_abort) begin
    if (rst || sync_abort) begin
      out_bit <= 1'b0;
      rd_act  <= 1'b0;
    end else begin
      out_bit <= rd_data[idx[4:0]];
      rd_act  <= data_ph && rd;
    end
  end

  assign sdio_o  = rd_act & out_bit;
  assign sdo     = rd_act & out_bit;
  assign sdio_oe = rd_act & ~three_wire;
endmodule

// File: rtl/srap_port.sv
module srap_port
  import srap_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic                      rst,
  input  logic                      sclk,
  input  logic                      sync_abort,
  input  logic                      sdi,
  input  logic                      sdio_i,
  output logic                      sdio_o,
  output logic                      sdio_oe,
  output logic                      sdo,
  input  logic                      sync_clk,
  input  logic                      io_update,
  output logic [NUM_REGS*REG_W-1:0] cfg_o
);
  localparam int ADDR_W = 5;

  logic                      lsb_first, three_wire, din;
  logic                      wr_en, rd, data_ph;
  logic [ADDR_W-1:0]         addr;
  logic [REG_W-1:0]          wr_data, rd_data;
  logic [CNT_W-1:0]          cnt, nbits;
  logic [NUM_REGS*REG_W-1:0] buf_flat;

  assign lsb_first  = cfg_o[0];
  assign three_wire = cfg_o[1];
  assign din        = three_wire ? sdi : sdio_i;

  srap_shift #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_shift (
    .rst(rst), .sclk(sclk), .sync_abort(sync_abort), .din(din),
    .lsb_first(lsb_first), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd(rd), .data_ph(data_ph), .cnt(cnt), .nbits(nbits)
  );

  srap_regbank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_bank (
    .rst(rst), .sclk(sclk), .wr_en(wr_en), .wr_addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .sync_clk(sync_clk), .io_update(io_update),
    .buf_flat(buf_flat), .act_flat(cfg_o)
  );

  srap_txout u_tx (
    .rst(rst), .sclk(sclk), .sync_abort(sync_abort), .lsb_first(lsb_first),
    .three_wire(three_wire), .data_ph(data_ph), .rd(rd), .cnt(cnt),
    .nbits(nbits), .rd_data(rd_data), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo)
  );
endmodule

// File: rtl/srap_chk.sv
module srap_chk #(
  parameter int NUM_REGS = 4
) (
  input logic                   rst,
  input logic                   sclk,
  input logic                   sync_clk,
  input logic                   sync_abort,
  input logic                   io_update,
  input logic                   sdio_oe,
  input logic                   sdo,
  input logic [NUM_REGS*32-1:0] cfg_o,
  input logic [NUM_REGS*32-1:0] buf_flat
);
  // R8
  cfg_hold_chk: assert property (@(posedge sync_clk) disable iff (rst)
    !io_update |=> $stable(cfg_o));

  // R8
  cfg_load_chk: assert property (@(posedge sync_clk) disable iff (rst)
    io_update |=> (cfg_o == $past(buf_flat)));

  // R6
  oe_mode_chk: assert property (@(posedge sclk) disable iff (rst || sync_abort)
    cfg_o[1] |-> !sdio_oe);

  // R7
  abort_quiet_chk: assert property (@(posedge sync_clk) disable iff (rst)
    sync_abort |-> (!sdio_oe && !sdo));

  for (genvar i = 1; i < NUM_REGS; i += 2) begin : g_odd
    // R9
    upper_zero_chk: assert property (@(posedge sync_clk) disable iff (rst)
      cfg_o[i*32+24 +: 8] == 8'h00);
  end
endmodule

bind srap_port srap_chk #(.NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/sim_srap_port.sv
module sim_srap_port;
  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 7;
  localparam int NREG       = 4;

  logic rst, sclk, sync_abort, sdi, sdio_i, sync_clk, io_update;
  logic sdio_o, sdio_oe, sdo;
  logic [NREG*32-1:0] cfg_o;

  int tests = 0, fails = 0;
  bit lsb = 0, tw = 0, oe_bad;

  srap_port #(.NUM_REGS(NREG)) u0 (
    .rst(rst), .sclk(sclk), .sync_abort(sync_abort), .sdi(sdi), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo), .sync_clk(sync_clk),
    .io_update(io_update), .cfg_o(cfg_o)
  );

  initial sync_clk = 0;
  always #(CLK_PERIOD/2) sync_clk = ~sync_clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input int a);
    return (a < NREG && a % 2 == 1) ? 3 : 4;
  endfunction

  task automatic xfer_bit(input logic b, output logic o);
    sdi = b; sdio_i = b;
    #SCK_HALF;
    o = tw ? sdo : sdio_o;
    if (!tw && !sdio_oe) oe_bad = 1;
    if (tw && sdio_oe) oe_bad = 1;
    sclk = 1;
    #SCK_HALF;
    sclk = 0;
  endtask

  task automatic send_ins(input logic [7:0] ins);
    logic o;
    for (int k = 0; k < 8; k++) begin
      sdi = lsb ? ins[k] : ins[7-k]; sdio_i = sdi;
      #SCK_HALF; sclk = 1; #SCK_HALF; sclk = 0;
    end
    o = 0;
  endtask

  task automatic wr(input logic [7:0] ins, input logic [31:0] val);
    int nb = nbytes(int'(ins[4:0])) * 8;
    send_ins(ins);
    for (int k = 0; k < nb; k++) begin
      sdi = lsb ? val[k] : val[nb-1-k]; sdio_i = sdi;
      #SCK_HALF; sclk = 1; #SCK_HALF; sclk = 0;
    end
  endtask

  task automatic rdreg(input int a, output logic [31:0] val);
    int nb = nbytes(a) * 8;
    logic o;
    val = 0; oe_bad = 0;
    send_ins(8'h80 | 8'(a));
    for (int k = 0; k < nb; k++) begin
      xfer_bit(1'b0, o);
      if (lsb) val[k] = o; else val[nb-1-k] = o;
    end
  endtask

  task automatic update();
    @(negedge sync_clk) io_update = 1;
    @(negedge sync_clk) io_update = 0;
  endtask

  task automatic t_reset();
    chk(cfg_o == '0, "R10 cfg", cfg_o[31:0], 0);
    chk(!sdio_oe && !sdo, "R10 pins", {sdio_oe, sdo}, 0);
  endtask

  task automatic t_msb_2wire();
    logic [31:0] v;
    wr(8'h02, 32'hDEADBEEF);
    #1 chk(cfg_o[95:64] == 0, "R8 no update yet", cfg_o[95:64], 0);
    rdreg(2, v);
    chk(v == 32'hDEADBEEF, "R4 R2 readback from buffer", v, 32'hDEADBEEF);
    chk(!oe_bad, "R6 oe high during read", {31'b0, oe_bad}, 0);
    #1 chk(!sdio_oe, "R6 oe low after read", {31'b0, sdio_oe}, 0);
    update();
    chk(cfg_o[95:64] == 32'hDEADBEEF, "R8 update", cfg_o[95:64], 32'hDEADBEEF);
  endtask

  task automatic t_lengths();
    logic [31:0] v;
    wr(8'h01, 32'hFFABCDEF);
    wr(8'h63, 32'h00123456); // bits 6:5 set
    rdreg(1, v);
    chk(v == 32'h00ABCDEF, "R3 R9 24-bit reg1", v, 32'h00ABCDEF);
    rdreg(3, v);
    chk(v == 32'h00123456, "R1 R3 reg3 after framing", v, 32'h00123456);
    update();
    chk(cfg_o[63:32] == 32'h00ABCDEF, "R9 active reg1", cfg_o[63:32], 32'h00ABCDEF);
  endtask

  task automatic t_lsb();
    logic [31:0] v;
    wr(8'h00, 32'h1);
    update(); lsb = 1;
    wr(8'h02, 32'h12345678);
    wr(8'h01, 32'h00A1B2C3);
    update();
    chk(cfg_o[95:64] == 32'h12345678, "R5 lsb write 32", cfg_o[95:64], 32'h12345678);
    chk(cfg_o[63:32] == 32'h00A1B2C3, "R5 lsb write 24", cfg_o[63:32], 32'h00A1B2C3);
    rdreg(2, v);
    chk(v == 32'h12345678, "R5 lsb read", v, 32'h12345678);
  endtask

  task automatic t_3wire();
    logic [31:0] v;
    wr(8'h00, 32'h3);
    update(); tw = 1;
    rdreg(1, v);
    chk(v == 32'h00A1B2C3, "R6 3-wire read on sdo", v, 32'h00A1B2C3);
    chk(!oe_bad, "R6 oe stays low in 3-wire", {31'b0, oe_bad}, 0);
    wr(8'h09, 32'hFFFFFFFF);
    rdreg(9, v);
    chk(v == 0, "R9 unknown addr reads zero", v, 0);
    rdreg(2, v);
    chk(v == 32'h12345678, "R9 unknown addr 4-byte framing", v, 32'h12345678);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    logic o;
    send_ins(8'h01);
    for (int k = 0; k < 10; k++) begin
      sdi = 1; #SCK_HALF; sclk = 1; #SCK_HALF; sclk = 0;
    end
    sync_abort = 1; #3; sync_abort = 0;
    update();
    chk(cfg_o[63:32] == 32'h00A1B2C3, "R7 partial write dropped", cfg_o[63:32], 32'h00A1B2C3);
    tw = 0;
    wr(8'h00, 32'h1); update();
    send_ins(8'h82);
    for (int k = 0; k < 5; k++) xfer_bit(1'b0, o);
    #1 chk(sdio_oe, "R6 oe high mid read", {31'b0, sdio_oe}, 1);
    sync_abort = 1; #1;
    chk(!sdio_oe && !sdo, "R7 abort drops oe", {30'b0, sdio_oe, sdo}, 0);
    #2 sync_abort = 0;
    rdreg(2, v);
    chk(v == 32'h12345678, "R7 new op after abort", v, 32'h12345678);
  endtask

  initial begin
    rst = 1; sclk = 0; sync_abort = 0; sdi = 0; sdio_i = 0; io_update = 0;
    #(CLK_PERIOD*3);
    t_reset();
    rst = 0;
    #(CLK_PERIOD*2);
    t_msb_2wire();
    t_lengths();
    t_lsb();
    t_3wire();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule